// File: doc/BRIEF.md
# Delayed-Branch Program Sequencer

This block is the program-counter and control-transfer unit of a small in-order coprocessor. On every cycle that it runs, it consumes one decoded instruction: the instruction class, a target address, a condition code and any flag update from the execute stage. It then produces the next fetch address. Conditional branch, call and return, as well as stop, each have three architectural delay slots. The three instructions that follow one of them in address order always execute. Any redirect takes effect only after the last of those slots.

A transfer does not test the newest flags. It tests the flag state left by the instruction four positions before it. Flag writes by the three instructions just ahead of the transfer do not influence the decision. A single return-address register serves call and return. Stop drains its slots and then halts. The sequencer stays frozen until a start pulse supplies a new entry address.

Top module: `dss_seq`

## Requirements
- R1: While reset is asserted, and afterwards until a start pulse, `halt_o` is 1 and `pc_o` is 0.
- R2: A start pulse loads `start_addr_i` into `pc_o` on the next cycle and clears halt. It also drops any pending redirect and clears the flag history. A start pulse is honoured in any state.
- R3: While running outside a redirect point, each cycle advances `pc_o` by one. Class codes are: 0 = plain, 1 = branch, 2 = call, 3 = return, 4 = stop.
- R4: A transfer or stop at address A is always followed by A+1, A+2 and A+3. The next address is then the target if the transfer is taken, or A+4 if it is not. Software must place no transfer or stop in those three slots, and the checker flags one that appears there.
- R5: The condition is evaluated on the flags (Z, N) left by the instruction four positions earlier. Condition codes are: 0 = always; 1 = EQ (Z); 2 = GT (not Z and not N); 3 = LEQ (Z or N). An instruction with no flag write carries the previous flags forward.
- R6: A taken call loads the return register with A+4. A taken return redirects to the value held in the return register.
- R7: An untaken call leaves the return register unchanged.
- R8: Stop at A raises `halt_o` after its three slots, with `pc_o` frozen at A+4. While halted, all instruction inputs are ignored.
- R9: A redirect target may itself hold a transfer. Its window starts on the first cycle at the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start pulse: load entry address and run |
| start_addr_i | input | AW | Entry address |
| cls_i | input | 3 | Class of the instruction at `pc_o` |
| cond_i | input | 2 | Condition code of that instruction |
| tgt_i | input | AW | Branch or call target |
| flag_we_i | input | 1 | Instruction writes flags |
| flag_z_i | input | 1 | New Z flag |
| flag_n_i | input | 1 | New N flag |
| pc_o | output | AW | Address of the instruction executing this cycle |
| halt_o | output | 1 | Sequencer halted |

## Verification
The assertions check these rules on every cycle:
- the address increments by one between redirect points;
- the address freezes while halted;
- a start pulse loads the entry address;
- halt is entered only at the end of a window;
- no transfer appears inside a delay slot.

Other behaviours can only be shown by the bench's scenarios, which compare the full address trace against a reference model. These are:
- the four-deep flag timing of conditions;
- the correct choice between taken and not taken for each condition code;
- the return address saved by a call and later used by a return;
- chained windows at redirect targets.

// File: rtl/dss_pkg.sv
package dss_pkg;
  typedef enum logic [2:0] {
    CLS_ALU  = 3'd0,
    CLS_BR   = 3'd1,
    CLS_CALL = 3'd2,
    CLS_RET  = 3'd3,
    CLS_STOP = 3'd4
  } cls_e;

  typedef enum logic [1:0] {
    CC_ALWAYS = 2'd0,
    CC_EQ     = 2'd1,
    CC_GT     = 2'd2,
    CC_LEQ    = 2'd3
  } cc_e;

  typedef struct packed {
    logic z;
    logic n;
  } flags_t;

  function automatic logic cc_true(flags_t f, cc_e c);
    unique case (c)
      CC_ALWAYS: return 1'b1;
      CC_EQ:     return f.z;
      CC_GT:     return !f.z && !f.n;
      default:   return f.z || f.n;
    endcase
  endfunction
endpackage

// File: rtl/dss_flag_hist.sv
module dss_flag_hist
  import dss_pkg::*;
#(
  parameter int DEPTH = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  logic   clr_i,
  input  logic   adv_i,
  input  logic   we_i,
  input  flags_t new_i,
  output flags_t old_o
);
  flags_t h_q [DEPTH];

  // stage 0 holds flags after the newest instruction
  generate
    for (genvar g = 0; g < DEPTH; g++) begin : g_stage
      flags_t d;
      if (g == 0) begin : g_head
        assign d = we_i ? new_i : h_q[0];
      end else begin : g_tail
        assign d = h_q[g-1];
      end
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)      h_q[g] <= '0;
        else if (clr_i)   h_q[g] <= '0;
        else if (adv_i)   h_q[g] <= d;
      end
    end
  endgenerate

  assign old_o = h_q[DEPTH-1];
endmodule

// File: rtl/dss_redirect.sv
module dss_redirect #(
  parameter int NSLOT = 3,
  parameter int AW    = 8,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          clr_i,
  input  logic          adv_i,
  input  logic          load_i,
  input  logic          take_i,
  input  logic          stop_i,
  input  logic [AW-1:0] tgt_i,
  output logic          busy_o,
  output logic          fire_o,
  output logic          fire_stop_o,
  output logic [AW-1:0] tgt_o,
  output logic [CW-1:0] cnt_o
);
  logic [CW-1:0] cnt_q;
  logic          take_q, stop_q;
  logic [AW-1:0] tgt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      take_q <= 1'b0;
      stop_q <= 1'b0;
      tgt_q  <= '0;
    end else if (clr_i) begin
      cnt_q  <= '0;
      take_q <= 1'b0;
      stop_q <= 1'b0;
    end else if (adv_i) begin
      if (load_i) begin
        cnt_q  <= CW'(NSLOT);
        take_q <= take_i;
        stop_q <= stop_i;
        tgt_q  <= tgt_i;
      end else if (cnt_q != '0) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  logic last_slot;
  assign last_slot   = adv_i && !clr_i && (cnt_q == CW'(1)) && take_q;
  assign busy_o      = cnt_q != '0;
  assign fire_o      = last_slot && !stop_q;
  assign fire_stop_o = last_slot && stop_q;
  assign tgt_o       = tgt_q;
  assign cnt_o       = cnt_q;
endmodule

// File: rtl/dss_ret_reg.sv
module dss_ret_reg #(
  parameter int AW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          we_i,
  input  logic [AW-1:0] d_i,
  output logic [AW-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   q_o <= '0;
    else if (we_i) q_o <= d_i;
  end
endmodule

// File: rtl/dss_seq.sv
module dss_seq
  import dss_pkg::*;
#(
  parameter int AW    = 8,
  parameter int NSLOT = 3
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          start_i,
  input  logic [AW-1:0] start_addr_i,
  input  logic [2:0]    cls_i,
  input  logic [1:0]    cond_i,
  input  logic [AW-1:0] tgt_i,
  input  logic          flag_we_i,
  input  logic          flag_z_i,
  input  logic          flag_n_i,
  output logic [AW-1:0] pc_o,
  output logic          halt_o
);
  localparam int HDEPTH = NSLOT + 1;
  localparam int CW     = $clog2(NSLOT + 1);

  logic [AW-1:0] pc_q, pc_d;
  logic          halt_q, halt_d;
  logic          run;
  cls_e          cls;
  flags_t        old_flags, new_flags;
  logic          is_xfer, busy, accept, take;
  logic          fire, fire_stop;
  logic [AW-1:0] rd_tgt, ret_q, xfer_tgt;
  logic [CW-1:0] slot_cnt;

  assign cls       = cls_e'(cls_i);
  assign run       = !halt_q && !start_i;
  assign new_flags = '{z: flag_z_i, n: flag_n_i};

  dss_flag_hist #(.DEPTH(HDEPTH)) u_hist (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start_i),
    .adv_i  (run),
    .we_i   (flag_we_i),
    .new_i  (new_flags),
    .old_o  (old_flags)
  );

  assign is_xfer  = cls inside {CLS_BR, CLS_CALL, CLS_RET, CLS_STOP};
  // transfers inside an open window are dropped (checker reports them)
  assign accept   = run && is_xfer && !busy;
  assign take     = (cls == CLS_STOP) || cc_true(old_flags, cc_e'(cond_i));
  assign xfer_tgt = (cls == CLS_RET) ? ret_q : tgt_i;

  dss_redirect #(.NSLOT(NSLOT), .AW(AW)) u_redir (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (start_i),
    .adv_i       (run),
    .load_i      (accept),
    .take_i      (take),
    .stop_i      (cls == CLS_STOP),
    .tgt_i       (xfer_tgt),
    .busy_o      (busy),
    .fire_o      (fire),
    .fire_stop_o (fire_stop),
    .tgt_o       (rd_tgt),
    .cnt_o       (slot_cnt)
  );

  dss_ret_reg #(.AW(AW)) u_ret (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (accept && (cls == CLS_CALL) && take),
    .d_i    (pc_q + AW'(NSLOT + 1)),
    .q_o    (ret_q)
  );

  always_comb begin
    pc_d   = pc_q;
    halt_d = halt_q;
    if (start_i) begin
      pc_d   = start_addr_i;
      halt_d = 1'b0;
    end else if (!halt_q) begin
      pc_d = fire ? rd_tgt : pc_q + 1'b1;
      if (fire_stop) halt_d = 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q   <= '0;
      halt_q <= 1'b1;
    end else begin
      pc_q   <= pc_d;
      halt_q <= halt_d;
    end
  end

  assign pc_o   = pc_q;
  assign halt_o = halt_q;
endmodule

// File: rtl/dss_seq_chk.sv
module dss_seq_chk #(
  parameter int AW    = 8,
  parameter int NSLOT = 3,
  localparam int CW   = $clog2(NSLOT + 1)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic [AW-1:0] start_addr_i,
  input logic [2:0]    cls_i,
  input logic [AW-1:0] pc_o,
  input logic          halt_o,
  input logic [CW-1:0] slot_cnt_i
);
  a_r3_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !start_i && slot_cnt_i != CW'(1)) |=> pc_o == $past(pc_o) + 1'b1);

  a_r8_freeze: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (halt_o && !start_i) |=> (halt_o && $stable(pc_o)));

  a_r2_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |=> (!halt_o && pc_o == $past(start_addr_i)));

  a_r8_halt_at_window_end: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !start_i) |=> (!halt_o || $past(slot_cnt_i) == CW'(1)));

  a_r4_no_xfer_in_slot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!halt_o && !start_i && slot_cnt_i != '0) |-> cls_i == 3'd0);
endmodule

bind dss_seq dss_seq_chk #(.AW(AW), .NSLOT(NSLOT)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .start_i      (start_i),
  .start_addr_i (start_addr_i),
  .cls_i        (cls_i),
  .pc_o         (pc_o),
  .halt_o       (halt_o),
  .slot_cnt_i   (slot_cnt)
);

// File: tb/dss_seq_tb.sv
`timescale 1ns/1ps
module dss_seq_tb;
  localparam int AW = 8;

  typedef struct {
    logic [2:0]    cls;
    logic [1:0]    cc;
    logic [AW-1:0] tgt;
    logic          we, z, n;
  } ins_t;

  logic          clk_i = 0, rst_ni = 0;
  logic          start_i = 0;
  logic [AW-1:0] start_addr_i = '0, tgt_i = '0;
  logic [2:0]    cls_i = '0;
  logic [1:0]    cond_i = '0;
  logic          flag_we_i = 0, flag_z_i = 0, flag_n_i = 0;
  logic [AW-1:0] pc_o;
  logic          halt_o;

  always #2.5 clk_i = ~clk_i;

  dss_seq #(.AW(AW), .NSLOT(3)) u_dut (.*);

  int n_chk = 0, n_fail = 0;
  ins_t prog [64];

  // reference state
  logic [AW-1:0] m_pc, m_ret, m_tgt;
  logic          m_halt, m_take, m_stop;
  int            m_left;
  logic [1:0]    m_fl [4];  // {z,n}; index 3 = four instructions back

  function automatic logic cond_ok(logic [1:0] f, logic [1:0] c);
    case (c)
      2'd0: return 1'b1;
      2'd1: return f[1];
      2'd2: return !f[1] && !f[0];
      default: return f[1] || f[0];
    endcase
  endfunction

  task automatic check(string tag, logic [AW-1:0] pc_exp, logic h_exp);
    n_chk++;
    if (pc_o !== pc_exp || halt_o !== h_exp) begin
      n_fail++;
      $display("FAIL %s pc=%0d halt=%0b expected pc=%0d halt=%0b", tag, pc_o, halt_o, pc_exp, h_exp);
    end
  endtask

  task automatic model(logic st, logic [AW-1:0] sa);
    ins_t i;
    logic [1:0] nf;
    if (st) begin
      m_pc = sa; m_halt = 0; m_left = 0; m_take = 0; m_stop = 0;
      for (int k = 0; k < 4; k++) m_fl[k] = 2'b00;
      return;
    end
    if (m_halt) return;
    i  = prog[m_pc[5:0]];
    nf = i.we ? {i.z, i.n} : m_fl[0];
    if (m_left > 0) begin
      m_left--;
      if (m_left == 0 && m_take) begin
        if (m_stop) begin m_halt = 1; m_pc = m_pc + 1; end
        else m_pc = m_tgt;
      end else m_pc = m_pc + 1;
    end else begin
      if (i.cls != 3'd0) begin
        m_left = 3;
        m_stop = (i.cls == 3'd4);
        m_take = m_stop || cond_ok(m_fl[3], i.cc);
        m_tgt  = (i.cls == 3'd3) ? m_ret : i.tgt;
        if (i.cls == 3'd2 && m_take) m_ret = m_pc + 4;
      end
      m_pc = m_pc + 1;
    end
    for (int k = 3; k > 0; k--) m_fl[k] = m_fl[k-1];
    m_fl[0] = nf;
  endtask

  // called at a negedge; returns at the next negedge after comparing
  task automatic step(logic st, logic [AW-1:0] sa);
    ins_t i;
    string tag;
    i = prog[m_pc[5:0]];
    tag = m_halt ? "R8" : (m_left > 0 ? "R4" : "R3");
    start_i = st; start_addr_i = sa;
    if (m_halt) begin  // junk while halted must be ignored
      cls_i = 3'($urandom_range(0, 4)); cond_i = 2'($urandom);
      tgt_i = AW'($urandom); flag_we_i = 1; flag_z_i = 1'($urandom); flag_n_i = 1'($urandom);
    end else begin
      cls_i = i.cls; cond_i = i.cc; tgt_i = i.tgt;
      flag_we_i = i.we; flag_z_i = i.z; flag_n_i = i.n;
    end
    @(posedge clk_i);
    model(st, sa);
    @(negedge clk_i);
    start_i = 0;
    if (st) tag = "R2";
    check(tag, m_pc, m_halt);
  endtask

  function automatic ins_t alu(logic we, logic z, logic n);
    ins_t r;
    r.cls = 3'd0; r.cc = 2'd0; r.tgt = '0; r.we = we; r.z = z; r.n = n;
    return r;
  endfunction

  function automatic ins_t xfer(logic [2:0] c, logic [1:0] cc, logic [AW-1:0] t);
    ins_t r;
    r.cls = c; r.cc = cc; r.tgt = t; r.we = 0; r.z = 0; r.n = 0;
    return r;
  endfunction

  task automatic clear_prog();
    for (int k = 0; k < 64; k++) prog[k] = alu(0, 0, 0);
  endtask

  task automatic run(int n);
    for (int k = 0; k < n; k++) step(0, '0);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    void'($urandom(32'd20250611));
    m_pc = '0; m_halt = 1; m_ret = '0; m_tgt = '0; m_left = 0; m_take = 0; m_stop = 0;
    for (int k = 0; k < 4; k++) m_fl[k] = 2'b00;
    clear_prog();
    repeat (3) @(negedge clk_i);
    check("R1 in reset", 8'd0, 1'b1);
    rst_ni = 1;
    @(negedge clk_i);
    check("R1 after reset", 8'd0, 1'b1);

    // R5: EQ taken on old Z though the three newer writes clear Z
    prog[10] = alu(1, 1, 0);
    prog[11] = alu(1, 0, 1); prog[12] = alu(1, 0, 1); prog[13] = alu(1, 0, 1);
    prog[14] = xfer(3'd1, 2'd1, 8'd40);
    prog[40] = xfer(3'd4, 2'd0, 8'd0);
    step(1, 8'd10);
    run(8);
    check("R5 EQ on old flags", 8'd40, 1'b0);
    run(4);
    check("R8 stop halts at A+4", 8'd44, 1'b1);
    run(5);
    check("R8 frozen while halted", 8'd44, 1'b1);

    // R5: GT not taken on the same history
    prog[14] = xfer(3'd1, 2'd2, 8'd40);
    step(1, 8'd10);
    run(8);
    check("R5 GT not taken", 8'd18, 1'b0);

    // R6/R7: call, return, untaken call keeps return register
    clear_prog();
    prog[0]  = xfer(3'd2, 2'd0, 8'd30);
    prog[31] = xfer(3'd3, 2'd0, 8'd0);
    prog[4]  = xfer(3'd2, 2'd3, 8'd50);
    prog[8]  = xfer(3'd3, 2'd0, 8'd0);
    step(1, 8'd0);
    run(4);
    check("R6 call redirect", 8'd30, 1'b0);
    run(5);
    check("R6 return to call+4", 8'd4, 1'b0);
    run(8);
    check("R7 untaken call keeps return", 8'd4, 1'b0);

    // R9: target holds another transfer
    clear_prog();
    prog[20] = xfer(3'd1, 2'd0, 8'd50);
    prog[50] = xfer(3'd1, 2'd0, 8'd60);
    prog[60] = xfer(3'd4, 2'd0, 8'd0);
    step(1, 8'd20);
    run(4);
    check("R9 first redirect", 8'd50, 1'b0);
    run(4);
    check("R9 chained redirect", 8'd60, 1'b0);
    run(4);
    check("R8 halt after chain", 8'd64, 1'b1);

    // random programs
    for (int p = 0; p < 6; p++) begin
      int free = 0;
      for (int k = 0; k < 64; k++) begin
        int r = $urandom_range(0, 9);
        if (free == 0 && k < 60 && r >= 6) begin
          logic [2:0] c = (r == 9) ? 3'd4 : 3'($urandom_range(1, 3));
          prog[k] = xfer(c, 2'($urandom), 8'($urandom_range(0, 63)));
          free = 3;
        end else begin
          prog[k] = alu(1'($urandom), 1'($urandom), 1'($urandom));
          if (free > 0) free--;
        end
      end
      step(1, 8'($urandom_range(0, 63)));
      for (int k = 0; k < 500; k++) begin
        if (m_halt && $urandom_range(0, 3) == 0) step(1, 8'($urandom_range(0, 63)));
        else if ($urandom_range(0, 299) == 0) step(1, 8'($urandom_range(0, 63)));
        else step(0, '0);
      end
    end
    summary();
  end
endmodule